// File: doc/BRIEF.md
# UART Register Front End

This block is the processor-facing side of a serial port. A small register space sits on a simple select/write strobe bus and exposes one data window, a flag word, a sticky error word with write-to-clear behaviour, a control word and a line-setup word. Characters written to the data window queue in a transmit FIFO. A handshake port drains that FIFO toward an external shifter.

Received characters arrive from an external deserializer on a valid strobe. Each one carries three line-error bits. The block stores it in a receive FIFO next to its error bits. Reading the data window returns the oldest character in the low byte and its error bits just above it, and removes that entry. Any error seen also accumulates in a sticky status word until software writes to the clear address. Enable bits gate both directions. A line-setup bit can shrink each FIFO to a single holding entry.

Top module: `uart_regs`

## Requirements
- R1: After reset the control and line words read 0, tx_valid_o and rts_o are low, and the flag word at address 1 reads 0x12 (tx_empty bit 4 and rx_empty bit 1 set; busy bit 0, tx_full bit 2 and rx_full bit 3 clear).
- R2: A write to address 0 queues wdata_i[7:0] in a 16-entry transmit FIFO. Characters leave on tx_data_o in write order. A write while tx_full (flag bit 2) is set is dropped.
- R3: A character is offered on tx_valid_o and removed on tx_ready_i only while control bit 0 (port enable) and control bit 1 (transmit enable) are both set.
- R4: Flag bit 0 (busy) is set while the transmit FIFO holds data or tx_active_i is high. Flag bit 4 (tx_empty) reflects the FIFO alone.
- R5: A character on rx_valid_i is stored only while control bits 0 and 2 (receive enable) are set. Reading address 0 returns the oldest character in bits 7:0, with framing in bit 8, parity in bit 9, break in bit 10 and overrun in bit 11 (rx_err_i bits 0, 1 and 2 map to framing, parity and break). The read removes that entry. rx_empty is flag bit 1.
- R6: Address 2 reads the sticky error word: framing in bit 0, parity in bit 1, break in bit 2, overrun in bit 3. Any write to address 2 clears it.
- R7: A character that arrives while the receive FIFO is full is discarded and sets sticky overrun. The next stored character carries bit 11 set.
- R8: When line bit 2 (FIFO enable) is clear, each FIFO holds a single entry, and its full flag rises after one entry.
- R9: Control bit 3 drives rts_o, and line bits 1:0 drive wlen_o (3 selects 8-bit). Writing 0 to address 3 clears every enable and rts_o.
- R10: Reading address 0 while the receive FIFO is empty returns 0 and removes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Bus access strobe, one cycle per access |
| wr_i | input | 1 | 1 write, 0 read |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i, valid during the access |
| tx_valid_o | output | 1 | Transmit character available |
| tx_data_o | output | 8 | Transmit character |
| tx_ready_i | input | 1 | Shifter takes the character |
| tx_active_i | input | 1 | Shifter still sending |
| rx_valid_i | input | 1 | Received character strobe |
| rx_data_i | input | 8 | Received character |
| rx_err_i | input | 3 | Framing, parity and break for that character |
| rts_o | output | 1 | Request-to-send level |
| wlen_o | output | 2 | Word-length setting |

## Verification
The bench fills the transmit FIFO while the port is disabled and then writes one more character. A design that accepted the extra write, or that let characters out early, would put an unexpected byte into the scoreboard. After the FIFO drains, the bench holds tx_active_i high. A busy flag that followed only the FIFO would read clear at that point. On the receive side, it overflows the FIFO by one character. A design that stored the extra character, or that did not mark the next stored character with overrun, would give a data word that does not match the queued expectation. The bench also runs single-entry mode, a read of an empty data window and reception while disabled. These catch a wrong full threshold, a spurious pop and ungated capture.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_DATA  = 3'd0;
  localparam logic [ADDR_W-1:0] A_FLAGS = 3'd1;
  localparam logic [ADDR_W-1:0] A_ERR   = 3'd2;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd3;
  localparam logic [ADDR_W-1:0] A_LINE  = 3'd4;

  typedef struct packed {
    logic rts;
    logic rx_en;
    logic tx_en;
    logic en;
  } ctrl_t;

  typedef struct packed {
    logic       fifo_en;
    logic [1:0] wlen;
  } line_t;
endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lim1_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [LVL_W-1:0] level_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [LVL_W-1:0] cnt_q;
  logic do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  // single-entry mode caps occupancy at one
  assign full_o  = lim1_i ? !empty_o : (cnt_q >= LVL_W'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rptr_q];
  assign level_o = cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= nxt(wptr_q);
      if (do_pop)  rptr_q <= nxt(rptr_q);
      if (do_push && !do_pop) cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= wdata_i;
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LVL_W'(DEPTH));
  // R2
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/uart_rx_capture.sv
module uart_rx_capture #(
  parameter int DATA_W = 8,
  parameter int FLAG_W = 3,
  localparam int ERR_W  = FLAG_W + 1,
  localparam int WORD_W = DATA_W + ERR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [FLAG_W-1:0] err_i,
  input  logic              full_i,
  input  logic              clr_i,
  output logic              push_o,
  output logic [WORD_W-1:0] word_o,
  output logic [ERR_W-1:0]  sticky_o
);
  logic ovr_pend_q, accept, lost;
  logic [ERR_W-1:0] sticky_q;

  assign accept = valid_i && enable_i;
  assign lost   = accept && full_i;
  assign push_o = accept && !full_i;
  assign word_o = {ovr_pend_q, err_i, data_i};
  assign sticky_o = sticky_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_pend_q <= 1'b0;
      sticky_q   <= '0;
    end else begin
      if (lost) ovr_pend_q <= 1'b1;
      else if (push_o) ovr_pend_q <= 1'b0;
      // new errors win over a same-cycle clear
      sticky_q <= (clr_i ? '0 : sticky_q)
                | (push_o ? {1'b0, err_i} : '0)
                | (lost ? {1'b1, {FLAG_W{1'b0}}} : '0);
    end
  end

  // R7
  overrun_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost |=> sticky_q[ERR_W-1]);
  // R6
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !accept) |=> (sticky_q == '0));
endmodule

// File: rtl/uart_regs.sv
module uart_regs
  import uart_regs_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int FLAG_W   = 3,
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 16,
  parameter int BUS_W    = 16,
  localparam int ERR_W   = FLAG_W + 1,
  localparam int RXW     = DATA_W + ERR_W,
  localparam int TX_LVL  = $clog2(TX_DEPTH + 1),
  localparam int RX_LVL  = $clog2(RX_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_data_o,
  input  logic              tx_ready_i,
  input  logic              tx_active_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic [FLAG_W-1:0] rx_err_i,
  output logic              rts_o,
  output logic [1:0]        wlen_o
);
  ctrl_t ctrl_q;
  line_t line_q;
  logic wr_hit, rd_hit;
  logic tx_push, tx_pop, tx_full, tx_empty, tx_go;
  logic rx_push, rx_pop, rx_full, rx_empty, rx_go, err_clr;
  logic [RXW-1:0] rx_word_in, rx_word_out;
  logic [ERR_W-1:0] sticky;
  logic [TX_LVL-1:0] tx_lvl;
  logic [RX_LVL-1:0] rx_lvl;
  logic [4:0] flags;

  assign wr_hit  = sel_i && wr_i;
  assign rd_hit  = sel_i && !wr_i;
  assign tx_push = wr_hit && (addr_i == A_DATA);
  assign err_clr = wr_hit && (addr_i == A_ERR);
  assign rx_pop  = rd_hit && (addr_i == A_DATA) && !rx_empty;
  assign tx_go   = ctrl_q.en && ctrl_q.tx_en;
  assign rx_go   = ctrl_q.en && ctrl_q.rx_en;
  assign tx_valid_o = tx_go && !tx_empty;
  assign tx_pop  = tx_valid_o && tx_ready_i;
  assign rts_o   = ctrl_q.rts;
  assign wlen_o  = line_q.wlen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      line_q <= '0;
    end else if (wr_hit) begin
      if (addr_i == A_CTRL) ctrl_q <= ctrl_t'(wdata_i[$bits(ctrl_t)-1:0]);
      if (addr_i == A_LINE) line_q <= line_t'(wdata_i[$bits(line_t)-1:0]);
    end
  end

  uart_fifo #(.WIDTH(DATA_W), .DEPTH(TX_DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni, .lim1_i(!line_q.fifo_en),
    .push_i(tx_push), .wdata_i(wdata_i[DATA_W-1:0]), .pop_i(tx_pop),
    .rdata_o(tx_data_o), .full_o(tx_full), .empty_o(tx_empty), .level_o(tx_lvl)
  );

  uart_rx_capture #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) u_rx_cap (
    .clk_i, .rst_ni, .enable_i(rx_go), .valid_i(rx_valid_i),
    .data_i(rx_data_i), .err_i(rx_err_i), .full_i(rx_full), .clr_i(err_clr),
    .push_o(rx_push), .word_o(rx_word_in), .sticky_o(sticky)
  );

  uart_fifo #(.WIDTH(RXW), .DEPTH(RX_DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni, .lim1_i(!line_q.fifo_en),
    .push_i(rx_push), .wdata_i(rx_word_in), .pop_i(rx_pop),
    .rdata_o(rx_word_out), .full_o(rx_full), .empty_o(rx_empty), .level_o(rx_lvl)
  );

  assign flags = {tx_empty, rx_full, tx_full, rx_empty, tx_active_i || !tx_empty};

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_DATA:  if (!rx_empty) rdata_o = BUS_W'(rx_word_out);
      A_FLAGS: rdata_o = BUS_W'(flags);
      A_ERR:   rdata_o = BUS_W'(sticky);
      A_CTRL:  rdata_o = BUS_W'(ctrl_q);
      A_LINE:  rdata_o = BUS_W'(line_q);
      default: rdata_o = '0;
    endcase
  end

  // R3
  tx_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_go && !tx_push) |=> (tx_lvl == $past(tx_lvl)));
  // R4
  busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_active_i |-> flags[0]);
  // R5
  rx_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_go && !rx_pop) |=> (rx_lvl == $past(rx_lvl)));
  // R9
  rts_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit && addr_i == A_CTRL && wdata_i == '0) |=> !rts_o && !tx_valid_o);
endmodule

// File: tb/uart_regs_bench.sv
module uart_regs_bench;
  logic clk = 0, rst_ni = 0;
  logic sel = 0, wr = 0;
  logic [2:0] addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic tx_valid, tx_ready = 0, tx_active = 0;
  logic [7:0] tx_data;
  logic rx_valid = 0;
  logic [7:0] rx_data = 0;
  logic [2:0] rx_err = 0;
  logic rts;
  logic [1:0] wlen;
  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] tx_q[$];
  logic [15:0] rx_q[$];
  logic ovr_next = 0;

  always #2 clk = ~clk;

  uart_regs u_uart_regs (
    .clk_i(clk), .rst_ni, .sel_i(sel), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready),
    .tx_active_i(tx_active), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_err_i(rx_err), .rts_o(rts), .wlen_o(wlen)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic bus_rd(logic [2:0] a, output logic [15:0] d);
    @(negedge clk); sel = 1; wr = 0; addr = a;
    #1 d = rdata;
    @(negedge clk); sel = 0;
  endtask

  // driver: tx write with scoreboard expectation
  task automatic tx_send(logic [7:0] c, bit expect_kept);
    if (expect_kept) tx_q.push_back(c);
    bus_wr(3'd0, {8'h00, c});
  endtask

  task automatic rx_send(logic [7:0] c, logic [2:0] e, bit expect_kept);
    if (expect_kept) begin
      rx_q.push_back({4'h0, ovr_next, e, c});
      ovr_next = 0;
    end else ovr_next = 1;
    @(negedge clk); rx_valid = 1; rx_data = c; rx_err = e;
    @(negedge clk); rx_valid = 0;
  endtask

  // monitor: read side of receive scoreboard
  task automatic rx_take(string req);
    logic [15:0] d;
    bus_rd(3'd0, d);
    if (rx_q.size() == 0) check(req, d, 16'hxxxx);
    else check(req, d, rx_q.pop_front());
  endtask

  // monitor: transmit handshake
  always @(negedge clk) begin
    #1;
    if (rst_ni && tx_valid && tx_ready) begin
      if (tx_q.size() == 0) check("R2 tx extra", {8'h0, tx_data}, 16'hxxxx);
      else check("R2 tx order", {8'h0, tx_data}, {8'h0, tx_q.pop_front()});
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1
    bus_rd(3'd1, d); check("R1 flags", d, 16'h0012);
    bus_rd(3'd3, d); check("R1 ctrl", d, 16'h0000);
    bus_rd(3'd4, d); check("R1 line", d, 16'h0000);
    check("R1 outputs", {14'h0, tx_valid, rts}, 16'h0);
    // R10
    bus_rd(3'd0, d); check("R10 empty read", d, 16'h0000);
    bus_wr(3'd4, 16'h0007);
    check("R9 wlen", {14'h0, wlen}, 16'h3);
    // R2/R3: fill while disabled, overflow write dropped
    tx_ready = 1;
    for (int i = 0; i < 16; i++) tx_send(8'h40 + 8'(i), 1);
    tx_send(8'hEE, 0);
    check("R3 gated", {15'h0, tx_valid}, 16'h0);
    bus_rd(3'd1, d); check("R2 tx_full", d & 16'h0015, 16'h0005);
    bus_wr(3'd3, 16'h0001);
    repeat (3) @(negedge clk);
    check("R3 tx_en off", {15'h0, tx_valid}, 16'h0);
    bus_wr(3'd3, 16'h000B);
    check("R9 rts", {15'h0, rts}, 16'h1);
    repeat (24) @(negedge clk);
    check("R2 drained", 16'(tx_q.size()), 16'h0);
    // R4
    tx_active = 1;
    bus_rd(3'd1, d); check("R4 busy active", d & 16'h0011, 16'h0011);
    tx_active = 0;
    bus_rd(3'd1, d); check("R4 idle", d & 16'h0011, 16'h0010);
    // R5: rx disabled ignored
    rx_send(8'h99, 3'b001, 0); ovr_next = 0;
    bus_rd(3'd1, d); check("R5 rx disabled", d & 16'h0002, 16'h0002);
    bus_rd(3'd2, d); check("R5 no sticky", d, 16'h0000);
    bus_wr(3'd3, 16'h000F);
    rx_send(8'h11, 3'b000, 1);
    rx_send(8'h22, 3'b001, 1);
    rx_send(8'h33, 3'b110, 1);
    bus_rd(3'd1, d); check("R5 rx nonempty", d & 16'h0002, 16'h0000);
    for (int i = 0; i < 3; i++) rx_take("R5 rx word");
    // R6
    bus_rd(3'd2, d); check("R6 sticky", d, 16'h0007);
    bus_wr(3'd2, 16'h1234);
    bus_rd(3'd2, d); check("R6 clear", d, 16'h0000);
    // R7
    for (int i = 0; i < 16; i++) rx_send(8'h80 + 8'(i), 3'b000, 1);
    bus_rd(3'd1, d); check("R7 rx_full", d & 16'h0008, 16'h0008);
    rx_send(8'hFF, 3'b000, 0);
    bus_rd(3'd2, d); check("R7 sticky ovr", d, 16'h0008);
    for (int i = 0; i < 16; i++) rx_take("R7 kept");
    rx_send(8'h5A, 3'b000, 1);
    rx_take("R7 flagged next");
    bus_rd(3'd0, d); check("R10 after drain", d, 16'h0000);
    // R8
    bus_wr(3'd3, 16'h0000);
    check("R9 zero ctrl", {15'h0, rts}, 16'h0);
    bus_wr(3'd4, 16'h0003);
    tx_send(8'h61, 1);
    bus_rd(3'd1, d); check("R8 one-entry full", d & 16'h0004, 16'h0004);
    tx_send(8'h62, 0);
    bus_wr(3'd3, 16'h0003);
    repeat (4) @(negedge clk);
    check("R8 single drained", 16'(tx_q.size()), 16'h0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hang expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule